// File: doc/BRIEF.md
# Hypercube Sum Reducer

This block adds up a set of equal-width operands by treating its storage as the nodes of a binary hypercube. It has 2^DIM node registers. A start pulse copies one operand into each of them in parallel. The reduction then runs one dimension per clock. It begins with the most significant label bit and works down to bit 0. In each step, every node whose label lies below 2^j takes the running sum of the node whose label differs from its own only in bit j, and adds that sum to its own value. The other nodes keep what they hold. The number of contributing nodes therefore halves with every step.

After DIM steps node 0 holds the total of all operands, reduced modulo 2^WIDTH. The block then raises a done flag that stays high until the next start. The result port always mirrors node 0, so a user that waits for done reads the final sum. A start that arrives while a reduction is running discards that reduction and begins a new one from the new operands.

Top module: `hcube_reduce`

## Requirements
- R1: While reset is held and in the cycle after it, done is 0 and result is 0.
- R2: The clock edge that samples start high loads operand slice n (bits n*WIDTH upward) into node n. Done is 0 from that edge until the reduction ends.
- R3: Done becomes 1 exactly DIM clock edges after the edge that sampled start, and not earlier.
- R4: When done is 1, result equals the sum of all 2^DIM loaded operands modulo 2^WIDTH.
- R5: While done is 1 and start is 0, done stays 1 and result holds its value, whatever the operand inputs do.
- R6: A start sampled during a running reduction, or after one has finished, reloads every node and restarts the full DIM-step sequence.
- R7: Steps run from dimension DIM-1 down to 0. After s steps, result equals the sum of the operands whose labels are multiples of 2^(DIM-s). Nodes outside the active set of a step keep their values.
- R8: Sums wrap at WIDTH bits. With every operand at 2^WIDTH-1, the final result is (2^DIM*(2^WIDTH-1)) mod 2^WIDTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load operands and begin a reduction |
| operands | input | 2^DIM*WIDTH | Packed operands, node n in slice n |
| done | output | 1 | Reduction finished, result valid |
| result | output | WIDTH | Running sum held by node 0 |

## Verification
The operands are loaded on the edge that samples start. The result then shows operand 0 one cycle later. Each following edge completes one step, so the partial sum after step s is due s+1 cycles after start, and done together with the full total is due DIM+1 cycles after start. The bench drives inputs on falling edges and checks at every falling edge of the sequence against partial sums it computes itself. A check therefore always lands after exactly the number of registered steps that the cycle count predicts. The bench also checks the hold period after done, and it checks a restart issued partway through a reduction.

// File: rtl/hcube_reduce_pkg.sv
package hcube_reduce_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_t;

    typedef struct packed {
        logic load;     // copy operands into every node
        logic advance;  // perform one reduction step this cycle
    } cmd_t;

    // width of a step index for a cube of the given dimension
    function automatic int step_bits(input int dim);
        return (dim > 1) ? $clog2(dim) : 1;
    endfunction

endpackage

// File: rtl/hcube_reduce_ctrl.sv
module hcube_reduce_ctrl
    import hcube_reduce_pkg::*;
#(
    parameter int DIM = 3,
    localparam int SW = step_bits(DIM)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output cmd_t          cmd,
    output logic [SW-1:0] step,
    output logic          done
);

    phase_t phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            step  <= '0;
        end else if (start) begin
            phase <= PH_RUN;
            step  <= SW'(DIM - 1);
        end else if (phase == PH_RUN) begin
            if (step == '0) begin
                phase <= PH_DONE;
            end else begin
                step <= step - SW'(1);
            end
        end
    end

    always_comb begin
        cmd.load    = start;
        cmd.advance = (phase == PH_RUN) && !start;
        done        = (phase == PH_DONE);
    end

    // R3: the last step is followed directly by done
    p_done_after_last_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd.advance && step == '0) |=> done);

    // R7: the dimension index counts down by one per step
    p_step_down_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd.advance && step != '0) |=> (cmd.advance || start) && (start || step == $past(step) - SW'(1)));

    // R6: a start always clears done on the next cycle
    p_start_clears_r6: assert property (@(posedge clk) disable iff (rst)
        start |=> !done);

    // R2: loading and stepping never coincide
    p_excl_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd.load, cmd.advance}));

endmodule

// File: rtl/hcube_reduce_node.sv
module hcube_reduce_node #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             add,
    input  logic [WIDTH-1:0] operand,
    input  logic [WIDTH-1:0] partner,
    output logic [WIDTH-1:0] sum
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sum <= '0;
        end else if (load) begin
            sum <= operand;
        end else if (add) begin
            sum <= sum + partner;   // wraps at WIDTH bits
        end
    end

    // R7: a node outside the active set keeps its value
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!load && !add) |=> sum == $past(sum));

    // R2: a load places the operand in the node
    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> sum == $past(operand));

endmodule

// File: rtl/hcube_reduce.sv
module hcube_reduce
    import hcube_reduce_pkg::*;
#(
    parameter int DIM   = 3,
    parameter int WIDTH = 16,
    localparam int P    = 1 << DIM,
    localparam int SW   = step_bits(DIM)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [P*WIDTH-1:0] operands,
    output logic               done,
    output logic [WIDTH-1:0]   result
);

    cmd_t          cmd;
    logic [SW-1:0] step;
    logic [WIDTH-1:0] sums [P];

    hcube_reduce_ctrl #(.DIM(DIM)) u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .start(start),
        .cmd  (cmd),
        .step (step),
        .done (done)
    );

    for (genvar g = 0; g < P; g++) begin : g_node
        logic [DIM-1:0]   label;
        logic [DIM-1:0]   mate;
        logic             active;
        logic [WIDTH-1:0] mate_sum;

        always_comb begin
            label    = DIM'(g);
            // neighbour across dimension "step": flip that label bit
            mate     = label ^ (DIM'(1) << step);
            // active set of this step: labels below 2^step
            active   = (label >> step) == '0;
            mate_sum = sums[mate];
        end

        hcube_reduce_node #(.WIDTH(WIDTH)) u_node (
            .clk    (clk),
            .rst    (rst),
            .load   (cmd.load),
            .add    (cmd.advance && active),
            .operand(operands[g*WIDTH +: WIDTH]),
            .partner(mate_sum),
            .sum    (sums[g])
        );
    end

    assign result = sums[0];

    // R5: a finished result is held until the next start
    p_done_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && result == $past(result)));

    // R1: no done right out of reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!done && result == '0));

endmodule

// File: tb/hcube_reduce_test.sv
module hcube_reduce_test;

    localparam int DIM = 3;
    localparam int W   = 8;
    localparam int P   = 1 << DIM;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [P*W-1:0]   operands = '0;
    logic             done;
    logic [W-1:0]     result;

    logic [W-1:0] ops [P];
    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    hcube_reduce #(.DIM(DIM), .WIDTH(W)) uut (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .operands(operands),
        .done    (done),
        .result  (result)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // sum of operands whose labels are multiples of 2^(DIM-s)
    function automatic logic [W-1:0] partial(input int s);
        logic [W-1:0] acc = '0;
        for (int n = 0; n < P; n++)
            if (n % (1 << (DIM - s)) == 0) acc = acc + ops[n];
        return acc;
    endfunction

    function automatic logic [P*W-1:0] pack();
        logic [P*W-1:0] v;
        for (int n = 0; n < P; n++) v[n*W +: W] = ops[n];
        return v;
    endfunction

    task automatic launch();
        @(negedge clk);
        start    = 1'b1;
        operands = pack();
        @(negedge clk);
        start    = 1'b0;
        check(result == ops[0], "R2", result, ops[0]);
        check(done == 1'b0, "R2", done, 0);
    endtask

    task automatic finish_run();
        for (int s = 1; s <= DIM; s++) begin
            @(negedge clk);
            check(result == partial(s), "R7", result, partial(s));
            if (s < DIM) check(done == 1'b0, "R3", done, 0);
            else begin
                check(done == 1'b1, "R3", done, 1);
                check(result == partial(DIM), "R4", result, partial(DIM));
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1", done, 0);
        check(result == '0, "R1", result, 0);
        rst = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R1", done, 0);
        check(result == '0, "R1", result, 0);

        // a single nonzero operand at each label in turn
        for (int k = 0; k < P; k++) begin
            for (int n = 0; n < P; n++) ops[n] = (n == k) ? W'(k + 1) : '0;
            launch();
            finish_run();
        end

        // arithmetic sweep of operand patterns
        for (int pat = 0; pat < 64; pat++) begin
            for (int n = 0; n < P; n++) ops[n] = W'(pat * 37 + n * 53 + pat * n * 11);
            launch();
            finish_run();
        end

        // R8: every operand at the maximum value
        for (int n = 0; n < P; n++) ops[n] = '1;
        launch();
        finish_run();
        check(result == W'(P * ((1 << W) - 1)), "R8", result, W'(P * ((1 << W) - 1)));

        // R5: hold while operands change and start stays low
        for (int h = 0; h < 4; h++) begin
            @(negedge clk);
            operands = {P{W'(h * 7 + 3)}};
            check(done == 1'b1, "R5", done, 1);
            check(result == W'(P * ((1 << W) - 1)), "R5", result, W'(P * ((1 << W) - 1)));
        end

        // R6: restart one step into a reduction
        for (int n = 0; n < P; n++) ops[n] = W'(n * 9 + 200);
        launch();
        @(negedge clk);
        check(result == partial(1), "R6", result, partial(1));
        for (int n = 0; n < P; n++) ops[n] = W'(n * 3 + 1);
        start    = 1'b1;
        operands = pack();
        @(negedge clk);
        start = 1'b0;
        check(result == ops[0], "R6", result, ops[0]);
        check(done == 1'b0, "R6", done, 0);
        finish_run();
        check(result == partial(DIM), "R6", result, partial(DIM));

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule